// File: doc/BRIEF.md
# Pulse-Width Serial Data Decoder

This block recovers a serial bit stream from a digitized pulse train in which each bit is carried by the length of a pulse. A short pulse means 0 and a long pulse means 1. The block synchronizes the incoming pulse signal and rejects pulses that are too brief. On each accepted rising edge it starts a one-shot sampling timer whose length lies between the short and the long pulse duration. When that timer runs out, the input level decides the bit: a pulse that is still high is long, and one that has already ended is short.

Two flags make up the outputs. The data flag drives the serial data output. An envelope flag is set by every long pulse. The OR of the two flags forms the reception-active signal. Two short pulses decoded back to back clear both flags, which marks the end of a reception. A retriggerable idle timer, restarted by every accepted pulse, clears both flags when the line stays quiet, so that a stray pulse cannot leave the outputs set for good.

All durations are parameters counted in clock cycles: `FILT_CYC` (minimum high time), `SAMPLE_CYC` (sampling delay), `IDLE_CYC` (gap timeout) and `SYNC_STAGES` (synchronizer depth). They must satisfy 2 <= `FILT_CYC`, 2 <= `SAMPLE_CYC` < `IDLE_CYC`, and `SYNC_STAGES` >= 2. In the formulas below, "cycles" means clock periods, counted from the first clock edge at which `rxIn` is high.

Top module: `pw_serial_decoder`

## Requirements
- R1: While `rst` is high, and after its release until a pulse is decoded, `serData` and `rxActive` are 0.
- R2: A pulse that stays high for at least `FILT_CYC`+`SAMPLE_CYC` cycles decodes as 1. `serData` and `rxActive` become 1 exactly `FILT_CYC`+`SAMPLE_CYC`+`SYNC_STAGES` cycles after the rising edge, and a single held-high pulse decodes only once.
- R3: A pulse that is high for at least `FILT_CYC` cycles but fewer than `FILT_CYC`+`SAMPLE_CYC` cycles decodes as 0 and drives `serData` to 0.
- R4: A single short pulse that follows a long one leaves `rxActive` at 1.
- R5: Two short pulses decoded one after the other, with no long pulse between them, drive `rxActive` to 0.
- R6: A pulse that is high for fewer than `FILT_CYC` cycles has no effect. It changes neither output and does not restart the idle timer.
- R7: A pulse that reaches its minimum high time while the sampling timer is still running is ignored and is not decoded.
- R8: If no pulse is accepted for `IDLE_CYC` cycles after the last accepted one, both flags are cleared and `serData` and `rxActive` go to 0.
- R9: The outputs change only on the clock edge that follows a sampling-timer expiry or an idle-timer expiry. `rxActive` is high whenever `serData` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rxIn | input | 1 | Digitized pulse train from the external comparator, asynchronous |
| serData | output | 1 | Recovered serial data bit (data flag) |
| rxActive | output | 1 | Reception-active envelope, OR of the data and envelope flags |

## Verification
The embedded assertions check a number of rules on every cycle:
- once started, the sampling timer counts down without interruption;
- a pulse is accepted only after its synchronized input has been high on consecutive cycles;
- the flags change only on decode or timeout events;
- a rise of `serData` always follows a long sample;
- a fall of `rxActive` always follows a short sample or an idle expiry.

Other behaviour only the bench scenarios can show: the exact decode latency, the pairing of consecutive short pulses that ends a reception, pulses ignored while a sample is pending, glitches that do not restart the idle timer, and the timeout clearing the outputs after a long silence.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  // Strobes produced by the datapath and consumed by the flag control.
  typedef struct packed {
    logic sampleStrobe; // sampling timer expires in this cycle
    logic sampleLevel;  // synchronized input level at the sampling instant
    logic idleExpire;   // idle timer expires in this cycle
  } pwdEvents_t;

endpackage

// File: rtl/pwd_datapath.sv
module pwd_datapath
  import pwd_pkg::*;
#(
  parameter int FILT_CYC    = 4,
  parameter int SAMPLE_CYC  = 20,
  parameter int IDLE_CYC    = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxIn,
  output pwdEvents_t events
);

  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int SW = $clog2(SAMPLE_CYC + 1);
  localparam int IW = $clog2(IDLE_CYC + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxSync;
  logic [FW-1:0]          highCnt;
  logic [SW-1:0]          sampleCnt;
  logic [IW-1:0]          idleCnt;
  logic                   accept;

  // Input synchronizer chain.
  generate
    if (SYNC_STAGES == 2) begin : g_sync2
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[0], rxIn};
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[SYNC_STAGES-2:0], rxIn};
      end
    end
  endgenerate

  assign rxSync = syncQ[SYNC_STAGES-1];

  // Glitch filter: count consecutive high cycles, saturating at the limit.
  always_ff @(posedge clk) begin
    if (rst)                          highCnt <= '0;
    else if (!rxSync)                 highCnt <= '0;
    else if (highCnt != FW'(FILT_CYC)) highCnt <= highCnt + 1'b1;
  end

  // A pulse is accepted once per high run, and only while no sample is pending.
  assign accept = rxSync && (highCnt == FW'(FILT_CYC - 1)) && (sampleCnt == '0);

  // One-shot sampling timer.
  always_ff @(posedge clk) begin
    if (rst)                  sampleCnt <= '0;
    else if (accept)          sampleCnt <= SW'(SAMPLE_CYC);
    else if (sampleCnt != '0) sampleCnt <= sampleCnt - 1'b1;
  end

  // Retriggerable idle timer.
  always_ff @(posedge clk) begin
    if (rst)                idleCnt <= '0;
    else if (accept)        idleCnt <= IW'(IDLE_CYC);
    else if (idleCnt != '0) idleCnt <= idleCnt - 1'b1;
  end

  assign events.sampleStrobe = (sampleCnt == SW'(1));
  assign events.sampleLevel  = rxSync;
  assign events.idleExpire   = (idleCnt == IW'(1));

  // R6: acceptance needs the synchronized input high on consecutive cycles.
  assert_glitch_reject_R6: assert property (@(posedge clk) disable iff (rst)
    accept |-> (rxSync && $past(rxSync)));

  // R7: a running sampling timer is never restarted or interrupted.
  assert_sample_no_retrigger_R7: assert property (@(posedge clk) disable iff (rst)
    (sampleCnt > SW'(1)) |=> (sampleCnt == $past(sampleCnt) - SW'(1)));

endmodule

// File: rtl/pwd_control.sv
module pwd_control
  import pwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pwdEvents_t events,
  output logic       serData,
  output logic       rxActive
);

  logic dataFf;
  logic envFf;
  logic shortSeen;

  always_ff @(posedge clk) begin
    if (rst || events.idleExpire) begin
      dataFf    <= 1'b0;
      envFf     <= 1'b0;
      shortSeen <= 1'b0;
    end else if (events.sampleStrobe) begin
      if (events.sampleLevel) begin
        dataFf    <= 1'b1;
        envFf     <= 1'b1;
        shortSeen <= 1'b0;
      end else begin
        dataFf <= 1'b0;
        if (shortSeen) begin
          envFf     <= 1'b0;
          shortSeen <= 1'b0;
        end else begin
          shortSeen <= 1'b1;
        end
      end
    end
  end

  assign serData  = dataFf;
  assign rxActive = dataFf | envFf;

  // R9: flags only move on a decode or timeout event.
  assert_flags_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(events.sampleStrobe || events.idleExpire) |-> ($stable(dataFf) && $stable(envFf)));

  // R2: a rising data output always follows a long sample.
  assert_data_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(serData) |-> $past(events.sampleStrobe && events.sampleLevel));

  // R5: the envelope only ends after a short sample or an idle expiry.
  assert_env_end_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rxActive) |-> $past(events.idleExpire || (events.sampleStrobe && !events.sampleLevel)));

  // R8: an idle expiry leaves both outputs low.
  assert_idle_clear_R8: assert property (@(posedge clk) disable iff (rst)
    events.idleExpire |=> (!rxActive && !serData));

endmodule

// File: rtl/pw_serial_decoder.sv
module pw_serial_decoder
  import pwd_pkg::*;
#(
  parameter int FILT_CYC    = 4,
  parameter int SAMPLE_CYC  = 20,
  parameter int IDLE_CYC    = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxIn,
  output logic serData,
  output logic rxActive
);

  pwdEvents_t events;

  pwd_datapath #(
    .FILT_CYC   (FILT_CYC),
    .SAMPLE_CYC (SAMPLE_CYC),
    .IDLE_CYC   (IDLE_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk   (clk),
    .rst   (rst),
    .rxIn  (rxIn),
    .events(events)
  );

  pwd_control i_control (
    .clk     (clk),
    .rst     (rst),
    .events  (events),
    .serData (serData),
    .rxActive(rxActive)
  );

  // R9: the envelope output always covers the data output.
  assert_env_covers_data_R9: assert property (@(posedge clk) disable iff (rst)
    serData |-> rxActive);

endmodule

// File: tb/test_pw_serial_decoder.sv
module test_pw_serial_decoder;

  localparam int FILT   = 4;
  localparam int SAMPLE = 20;
  localparam int IDLE   = 200;
  localparam int SYNC   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxIn = 1'b0;
  logic serData, rxActive;

  int nChecks = 0;
  int nFails  = 0;
  int tick    = 0;
  bit done    = 1'b0;

  // Behavioural model state.
  bit expData  = 1'b0;
  bit expEnv   = 1'b0;
  bit expShort = 1'b0;
  bit hasAcc   = 1'b0;
  int tAcc     = 0;

  always #10 clk = ~clk;

  pw_serial_decoder #(
    .FILT_CYC(FILT), .SAMPLE_CYC(SAMPLE), .IDLE_CYC(IDLE), .SYNC_STAGES(SYNC)
  ) i_pw_serial_decoder (
    .clk(clk), .rst(rst), .rxIn(rxIn), .serData(serData), .rxActive(rxActive)
  );

  function automatic bit isAccepted(int len);
    return len >= FILT;
  endfunction

  function automatic bit isLong(int len);
    return len >= FILT + SAMPLE;
  endfunction

  task automatic chk(string req, logic act, logic exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0b expected=%0b at tick %0d", req, what, act, exp, tick);
    end
  endtask

  task automatic modelClear();
    expData = 1'b0; expEnv = 1'b0; expShort = 1'b0;
  endtask

  // Drive one pulse of len high cycles followed by gap low cycles.
  // acc=0 forces the model to treat the pulse as ignored (sampler busy).
  // The outputs are observed on the last gap cycle, when doCheck is set.
  task automatic runPulse(int len, int gap, bit acc, bit doCheck, string req);
    int startT = tick;
    if (acc && isAccepted(len)) begin
      if (hasAcc && (startT - tAcc >= IDLE)) modelClear();
      hasAcc = 1'b1;
      tAcc   = startT;
      if (isLong(len)) begin
        expData = 1'b1; expEnv = 1'b1; expShort = 1'b0;
      end else begin
        expData = 1'b0;
        if (expShort) begin expEnv = 1'b0; expShort = 1'b0; end
        else expShort = 1'b1;
      end
    end
    for (int i = 0; i < len + gap; i++) begin
      @(negedge clk);
      if (i == len + gap - 1 && doCheck) begin
        if (hasAcc && (tick >= tAcc + FILT + IDLE + 2)) modelClear();
        chk(req, serData, expData, "serData");
        chk(req, rxActive, expData | expEnv, "rxActive");
      end
      rxIn = (i < len);
      tick++;
    end
  endtask

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk("R1", serData, 1'b0, "serData in reset");
    chk("R1", rxActive, 1'b0, "rxActive in reset");
    @(negedge clk);
    rst = 1'b0;
    chk("R1", serData, 1'b0, "serData after reset");
    chk("R1", rxActive, 1'b0, "rxActive after reset");

    // Long, then short (R4), then short again (R5).
    runPulse(30, 40, 1'b1, 1'b1, "R2");
    runPulse(10, 40, 1'b1, 1'b1, "R4");
    runPulse(10, 40, 1'b1, 1'b1, "R5");

    // Exact latency of a long pulse (R2): one cycle before and at the update.
    runPulse(FILT + SAMPLE, 0, 1'b1, 1'b0, "R2");
    for (int i = FILT + SAMPLE; i < FILT + SAMPLE + SYNC + 1; i++) begin
      @(negedge clk);
      if (i == FILT + SAMPLE + SYNC - 1) chk("R2", serData, 1'b0, "serData before latency");
      if (i == FILT + SAMPLE + SYNC)     chk("R2", serData, 1'b1, "serData at latency");
      rxIn = 1'b0;
      tick++;
    end
    runPulse(0, 40, 1'b1, 1'b1, "R2");

    // Short pulse after a long one keeps the envelope (R3, R4).
    runPulse(SAMPLE + FILT - 1, 40, 1'b1, 1'b1, "R3");

    // Glitch ignored (R6).
    runPulse(30, 40, 1'b1, 1'b1, "R2");
    runPulse(FILT - 1, 40, 1'b1, 1'b1, "R6");
    // Glitches do not restart the idle timer (R6, R8).
    runPulse(2, 100, 1'b1, 1'b1, "R6");
    runPulse(2, 100, 1'b1, 1'b1, "R8");

    // Pulse during pending sample is ignored (R7).
    runPulse(30, 40, 1'b1, 1'b1, "R2");
    runPulse(8, 4, 1'b1, 1'b0, "R7");
    runPulse(8, 40, 1'b0, 1'b1, "R7");
    runPulse(10, 40, 1'b1, 1'b1, "R7");

    // Held-high pulse decodes once (R2), then idle timeout (R8).
    runPulse(80, 40, 1'b1, 1'b1, "R2");
    runPulse(30, 240, 1'b1, 1'b1, "R8");

    // Constrained random pulse trains.
    for (int n = 0; n < 80; n++) begin
      int cls = $urandom_range(0, 9);
      int len;
      int gap;
      string tag;
      if (cls < 2) begin
        len = $urandom_range(1, FILT - 1); tag = "R6";
      end else if (cls < 6) begin
        len = $urandom_range(FILT + 2, FILT + SAMPLE - 1); tag = "R3";
      end else begin
        len = $urandom_range(FILT + SAMPLE, FILT + SAMPLE + 16); tag = "R2";
      end
      if ($urandom_range(0, 7) == 0) begin
        gap = $urandom_range(IDLE + 30, IDLE + 60); tag = "R8";
      end else begin
        gap = $urandom_range(28, 60);
      end
      runPulse(len, gap, 1'b1, 1'b1, tag);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule